// File: doc/BRIEF.md
# Clock-Saving Pseudorandom Pattern Generator

This block is a pseudorandom stimulus source for scan-based test. After a nonzero seed is loaded it emits one W-bit pattern per clock, in exactly the order a maximal-length, right-shifting Fibonacci LFSR would produce. The LFSR register only advances on "anchor" cycles. Whenever the next pattern is a one-bit right rotation of the current one, a rotate-right shifter supplies it and the LFSR register stays frozen.

A three-state controller (idle/initialise, anchor/decide, rotate/shift) makes the choice on every cycle. It also counts the patterns it emits and restarts from the stored seed after one full period of 2^W-1 patterns. The `lfsr_active_o` flag marks the anchor cycles. Only those patterns would need storing, because every other pattern is derived from its predecessor by rotation.

Top module: `lfsr_clk_saving_gen`

## Requirements
- R1: While `rst_i` is high, and afterwards until a nonzero seed is loaded, `valid_o` and `lfsr_active_o` are 0 and `pattern_o` is all zeros.
- R2: When `load_i` is sampled high with a nonzero `seed_i`, on the next cycle `valid_o`=1, `lfsr_active_o`=1 and `pattern_o` equals the seed.
- R3: When `load_i` is sampled high with `seed_i` all zeros, the block returns to idle on the next cycle (`valid_o`=0, `pattern_o`=0) and stays there until a nonzero load.
- R4: The emitted patterns follow the LFSR order. Each new pattern is {fb, p[W-1:1]}, where fb is the XOR of the bits of the previous pattern p selected by the tap mask. For W=3 and seed 001 the order is 001, 100, 010, 101, 110, 111, 011.
- R5: A pattern is produced by rotation (`lfsr_active_o`=0) exactly when fb of the previous pattern equals that pattern's bit 0, so that the new pattern is the right rotation of the previous one. Otherwise it is an anchor (`lfsr_active_o`=1), and the LFSR is reloaded from the last word and stepped once. While rotating, the LFSR register holds its value.
- R6: Over one period the number of anchor cycles follows from R5. For W=3 with seed 001 there are 4 anchors (001, 101, 111, 011). For W=4 with seed 0001 there are 8 anchors (0001, 1001, 1011, 0101, 1101, 1111, 0111, 0011).
- R7: After 2^W-1 patterns have been emitted, the next pattern is the stored seed, flagged as an anchor, and the sequence repeats.
- R8: A load with a nonzero seed is honoured in any state and restarts the sequence from that seed on the next cycle, with the pattern count cleared.
- R9: Whenever `valid_o` is 1, `pattern_o` is nonzero.
- R10: The tap mask (bit i set means bit i feeds the XOR) is selected from W: W=2: 11, W=3: 011, W=4: 0011, W=5: 00101, W=6: 000011, W=7: 0000011, W=8: 00011101. W ranges from 2 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Seed strobe; `seed_i` is captured on this cycle |
| seed_i | input | W | Seed word; all zeros means stop |
| pattern_o | output | W | Current test pattern |
| valid_o | output | 1 | Pattern on `pattern_o` is valid |
| lfsr_active_o | output | 1 | Current pattern came from an LFSR step (anchor) |

## Verification
An internal fault appears at the ports on the very next valid cycle. A wrong rotate/anchor decision, a wrong tap or a stale LFSR word all show up as a `pattern_o` value that differs from the reference successor. A wrong decision also shows up as a flipped `lfsr_active_o`. A pattern counter that is off by one shows up only at the period boundary, where the seed reappears either too early or too late. For this reason the stream is compared over two full periods, and the anchor count is checked for each period.

// File: rtl/lfsr_cs_pkg.sv
package lfsr_cs_pkg;

    typedef enum logic [1:0] {
        PG_INIT   = 2'd0,
        PG_ANCHOR = 2'd1,
        PG_ROTATE = 2'd2
    } pg_state_e;

    // Feedback tap mask for a right-shifting Fibonacci register:
    // bit i set means state bit i takes part in the feedback XOR.
    function automatic logic [7:0] tap_mask(input int unsigned width);
        logic [7:0] m;
        case (width)
            2:       m = 8'b0000_0011;
            3:       m = 8'b0000_0011;
            4:       m = 8'b0000_0011;
            5:       m = 8'b0000_0101;
            6:       m = 8'b0000_0011;
            7:       m = 8'b0000_0011;
            8:       m = 8'b0001_1101;
            default: m = 8'b0000_0011;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lfsr_cs_core.sv
module lfsr_cs_core #(
    parameter int unsigned W = 3
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         en_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] q_o
);
    import lfsr_cs_pkg::*;

    localparam logic [7:0]   TAPS8 = tap_mask(W);
    localparam logic [W-1:0] TAPS  = TAPS8[W-1:0];

    logic [W-1:0] state_d, state_q;
    logic         fb;

    always_comb begin
        fb      = ^(src_i & TAPS);
        state_d = state_q;
        if (ld_i) begin
            state_d = ld_val_i;
        end else if (en_i) begin
            state_d = {fb, src_i[W-1:1]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '0;
        else       state_q <= state_d;
    end

    assign q_o = state_q;

    // R5: the register is frozen whenever it is neither loaded nor stepped
    a_r5_lfsr_held: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ld_i && !en_i) |=> $stable(state_q));

endmodule

// File: rtl/lfsr_cs_rotator.sv
module lfsr_cs_rotator #(
    parameter int unsigned W = 3
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         ld_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] rot_d, rot_q;

    always_comb begin
        rot_d = rot_q;
        if (ld_i) rot_d = {src_i[0], src_i[W-1:1]};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) rot_q <= '0;
        else       rot_q <= rot_d;
    end

    assign q_o = rot_q;

    // R5: the shifter only changes when told to rotate
    a_r5_rot_held: assert property (@(posedge clk_i) disable iff (rst_i)
        !ld_i |=> $stable(rot_q));

endmodule

// File: rtl/lfsr_cs_ctrl.sv
module lfsr_cs_ctrl #(
    parameter int unsigned W = 3
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   load_i,
    input  logic [W-1:0]           seed_i,
    input  logic [W-1:0]           word_i,
    output lfsr_cs_pkg::pg_state_e st_o,
    output logic                   lfsr_ld_o,
    output logic [W-1:0]           lfsr_ld_val_o,
    output logic                   lfsr_en_o,
    output logic                   rot_ld_o
);
    import lfsr_cs_pkg::*;

    localparam logic [7:0]   TAPS8  = tap_mask(W);
    localparam logic [W-1:0] TAPS   = TAPS8[W-1:0];
    localparam int unsigned  PERIOD = (1 << W) - 1;
    localparam int unsigned  CW     = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);

    typedef struct packed {
        pg_state_e     st;
        logic [CW-1:0] cnt;
        logic [W-1:0]  seed;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;
    logic  rotatable;

    always_comb begin
        rotatable     = ((^(word_i & TAPS)) == word_i[0]);
        ctrl_d        = ctrl_q;
        lfsr_ld_o     = 1'b0;
        lfsr_ld_val_o = seed_i;
        lfsr_en_o     = 1'b0;
        rot_ld_o      = 1'b0;
        if (load_i) begin
            ctrl_d.cnt = '0;
            if (seed_i == '0) begin
                ctrl_d.st = PG_INIT;
            end else begin
                ctrl_d.st   = PG_ANCHOR;
                ctrl_d.seed = seed_i;
                lfsr_ld_o   = 1'b1;
            end
        end else if (ctrl_q.st != PG_INIT) begin
            if (ctrl_q.cnt == LAST) begin
                ctrl_d.st     = PG_ANCHOR;
                ctrl_d.cnt    = '0;
                lfsr_ld_o     = 1'b1;
                lfsr_ld_val_o = ctrl_q.seed;
            end else begin
                ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                if (rotatable) begin
                    ctrl_d.st = PG_ROTATE;
                    rot_ld_o  = 1'b1;
                end else begin
                    ctrl_d.st = PG_ANCHOR;
                    lfsr_en_o = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q.st   <= PG_INIT;
            ctrl_q.cnt  <= '0;
            ctrl_q.seed <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign st_o = ctrl_q.st;

    // R7: the pattern index never reaches the period
    a_r7_count_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_q.cnt < CW'(PERIOD));

    // R7: after the last pattern of a period the seed comes back as an anchor
    a_r7_wrap_to_seed: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_q.st != PG_INIT && ctrl_q.cnt == LAST && !load_i)
        |=> (ctrl_q.st == PG_ANCHOR && word_i == $past(ctrl_q.seed)));

    // R3: a zero seed sends the block back to idle
    a_r3_zero_seed_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && seed_i == '0) |=> ctrl_q.st == PG_INIT);

    // R2, R8: a nonzero seed starts from that seed in any state
    a_r8_reload: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && seed_i != '0)
        |=> (ctrl_q.st == PG_ANCHOR && word_i == $past(seed_i) && ctrl_q.cnt == '0));

endmodule

// File: rtl/lfsr_clk_saving_gen.sv
module lfsr_clk_saving_gen #(
    parameter int unsigned W = 3
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] pattern_o,
    output logic         valid_o,
    output logic         lfsr_active_o
);
    import lfsr_cs_pkg::*;

    localparam logic [7:0]   TAPS8 = tap_mask(W);
    localparam logic [W-1:0] TAPS  = TAPS8[W-1:0];

    pg_state_e    st;
    logic         lfsr_ld, lfsr_en, rot_ld;
    logic [W-1:0] lfsr_ld_val, lfsr_word, rot_word, cur_word;

    lfsr_cs_ctrl #(.W(W)) u_ctrl (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .load_i        (load_i),
        .seed_i        (seed_i),
        .word_i        (cur_word),
        .st_o          (st),
        .lfsr_ld_o     (lfsr_ld),
        .lfsr_ld_val_o (lfsr_ld_val),
        .lfsr_en_o     (lfsr_en),
        .rot_ld_o      (rot_ld)
    );

    lfsr_cs_core #(.W(W)) u_core (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .ld_i     (lfsr_ld),
        .ld_val_i (lfsr_ld_val),
        .en_i     (lfsr_en),
        .src_i    (cur_word),
        .q_o      (lfsr_word)
    );

    lfsr_cs_rotator #(.W(W)) u_rot (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ld_i  (rot_ld),
        .src_i (cur_word),
        .q_o   (rot_word)
    );

    always_comb begin
        cur_word      = (st == PG_ROTATE) ? rot_word : lfsr_word;
        valid_o       = (st != PG_INIT);
        lfsr_active_o = (st == PG_ANCHOR);
        pattern_o     = valid_o ? cur_word : '0;
    end

    // Successor of the visible pattern, used only by the order check.
    logic [W-1:0] succ_w;
    assign succ_w = {^(pattern_o & TAPS), pattern_o[W-1:1]};

    // R9: a valid pattern is never all zeros
    a_r9_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> pattern_o != '0);

    // R4: consecutive valid patterns follow the LFSR step
    a_r4_order: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && $past(valid_o) && !$past(load_i)) |-> pattern_o == $past(succ_w));

    // R5: a non-anchor pattern is the right rotation of its predecessor
    a_r5_rotation: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && !lfsr_active_o)
        |-> $past(pattern_o) == {pattern_o[W-2:0], pattern_o[W-1]});

    // R1: the anchor flag only appears on valid patterns
    a_r1_active_needs_valid: assert property (@(posedge clk_i) disable iff (rst_i)
        lfsr_active_o |-> valid_o);

endmodule

// File: tb/sim_lfsr_clk_saving_gen.sv
module sim_lfsr_clk_saving_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load0 = 1'b0, load1 = 1'b0;
    logic [2:0] seed0 = '0;
    logic [3:0] seed1 = '0;
    logic [2:0] pat0;
    logic [3:0] pat1;
    logic       val0, act0, val1, act1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lfsr_clk_saving_gen #(.W(3)) u0 (
        .clk_i(clk), .rst_i(rst), .load_i(load0), .seed_i(seed0),
        .pattern_o(pat0), .valid_o(val0), .lfsr_active_o(act0));

    lfsr_clk_saving_gen #(.W(4)) u1 (
        .clk_i(clk), .rst_i(rst), .load_i(load1), .seed_i(seed1),
        .pattern_o(pat1), .valid_o(val1), .lfsr_active_o(act1));

    // {anchor flag, pattern} for W=3, seed 001, one period plus the wrap
    localparam logic [3:0] TBL3 [8] = '{
        4'b1_001, 4'b0_100, 4'b0_010, 4'b1_101,
        4'b0_110, 4'b1_111, 4'b1_011, 4'b1_001
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int anchors;
        logic [3:0] exp4;
        logic       exp_act;
        logic       fb;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle during reset
        check(!val0 && !act0 && pat0 == 0, "R1 reset u0", {val0, act0, pat0}, 0);
        check(!val1 && !act1 && pat1 == 0, "R1 reset u1", {val1, act1, pat1}, 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!val0 && pat0 == 0, "R1 idle without seed", {val0, pat0}, 0);

        // R2, R4, R5, R7: W=3 stream from the table
        load0 = 1'b1; seed0 = 3'b001;
        @(negedge clk);
        load0 = 1'b0;
        anchors = 0;
        for (int i = 0; i < 8; i++) begin
            check(val0 && pat0 == TBL3[i][2:0], "R4 W3 pattern", pat0, TBL3[i][2:0]);
            check(act0 == TBL3[i][3], "R5 W3 anchor flag", act0, TBL3[i][3]);
            if (i < 7 && act0) anchors++;
            @(negedge clk);
        end
        check(anchors == 4, "R6 W3 anchors per period", anchors, 4);

        // R8: reload mid-run with 110
        load0 = 1'b1; seed0 = 3'b110;
        @(negedge clk);
        load0 = 1'b0;
        check(val0 && act0 && pat0 == 3'b110, "R8 reload first", {act0, pat0}, 4'b1110);
        @(negedge clk);
        check(act0 && pat0 == 3'b111, "R8 reload second", {act0, pat0}, 4'b1111);
        @(negedge clk);
        check(act0 && pat0 == 3'b011, "R8 reload third", {act0, pat0}, 4'b1011);

        // R3: zero seed stops the stream
        load0 = 1'b1; seed0 = 3'b000;
        @(negedge clk);
        load0 = 1'b0;
        check(!val0 && !act0 && pat0 == 0, "R3 zero seed", {val0, act0, pat0}, 0);
        @(negedge clk);
        @(negedge clk);
        check(!val0 && pat0 == 0, "R3 stays idle", {val0, pat0}, 0);

        // R4, R5, R6, R7, R9, R10: W=4 over two periods against a model
        load1 = 1'b1; seed1 = 4'b0001;
        @(negedge clk);
        load1 = 1'b0;
        exp4 = 4'b0001;
        exp_act = 1'b1;
        anchors = 0;
        for (int k = 0; k < 30; k++) begin
            check(val1 && pat1 == exp4, "R10 W4 pattern", pat1, exp4);
            check(act1 == exp_act, "R5 W4 anchor flag", act1, exp_act);
            check(!val1 || pat1 != 0, "R9 nonzero", pat1, exp4);
            if (k % 15 == 0) check(pat1 == 4'b0001 && act1, "R7 W4 period start", pat1, 1);
            if (exp_act) anchors++;
            if (k % 15 == 14) begin
                check(anchors == 8, "R6 W4 anchors per period", anchors, 8);
                anchors = 0;
                exp4 = 4'b0001;
                exp_act = 1'b1;
            end else begin
                fb = exp4[0] ^ exp4[1];
                exp_act = (fb != exp4[0]);
                exp4 = {fb, exp4[3:1]};
            end
            @(negedge clk);
        end

        // R1: reset in the middle of a run
        rst = 1'b1;
        @(negedge clk);
        check(!val1 && !act1 && pat1 == 0, "R1 reset mid-run", {val1, act1, pat1}, 0);
        rst = 1'b0;
        @(negedge clk);

        finish_run();
    end

endmodule